// File: doc/BRIEF.md
# Small-Page NAND Flash Target Command Interface

This block is the device side of a small-page NAND-style flash memory, written to be synthesized and used as a target model next to a flash controller. It watches an 8-bit I/O bus together with chip-enable, write-enable, read-enable, command-latch and address-latch strobes. All strobes are sampled on the system clock. Captured bytes are sorted into commands, address cycles and program data. Data, identifier and status bytes are driven back out on read-enable falling edges. The block also drives a ready flag.

A reduced-depth on-chip array stands in for the cell array. Each page holds 528 bytes: a main area of two 256-byte halves followed by a 16-byte spare area. Pages are grouped into erase blocks. Program, erase and sequential page read all operate on that array. Program and erase take as many clock cycles as they have bytes to commit, and the ready flag is low for that whole time.

Top module: `nand_cmd_if`

## Requirements
- R1: After reset, rdy is 1, io_oe is 0 and the array reads all FFh. A status read returns C0h while wp_n is high.
- R2: A bus byte is accepted only on a sampled rising edge of we_n while ce_n is low. It is a command when cle=1 and ale=0, and an address when ale=1 and cle=0. A write-enable edge taken while ce_n is high changes nothing.
- R3: The area pointer sets where the column starts: command 00h starts at column 0, 01h at column 256 and 50h at column 512. The column cycle byte is added to that base. In the spare area only its low 4 bits are used. The pointer stays as set until another pointer command or FFh arrives.
- R4: Each sampled falling edge of re_n, taken while ce_n=0, we_n=1, cle=0 and ale=0, latches one byte onto io_out and advances the column by one. io_out holds its value between such edges. io_oe is 1 only while those conditions hold and re_n is low.
- R5: A page read that steps past column 527 continues at the area base of the next page. It does not move out of the current block. At the last column of a block's last page, further reads repeat that byte.
- R6: Program is 80h, one column cycle, two row cycles, any number of data bytes starting at the column, then 10h. Each array byte becomes old AND new data. Bytes not loaded stay unchanged.
- R7: Erase is 60h, two row cycles, then D0h. It sets every byte of the addressed block to FFh and leaves other blocks untouched.
- R8: After 90h, the first two reads return 20h then 75h. Any address cycle in between is ignored.
- R9: After 70h, every read returns the live status {wp_n, rdy, 5'b0, fail} until another command is written.
- R10: A 10h or D0h confirm written while wp_n is low starts no operation and leaves the array unchanged. rdy stays 1, and the status fail bit (bit 0) is set. An accepted confirm clears the fail bit.
- R11: rdy is low for RD_BUSY cycles after the third address cycle of a read and after each page crossing. It is low for 528 cycles during program commit and for one block's byte count during erase. While rdy is low, only 70h and FFh are accepted, and FFh ends the operation at once.
- R12: Read and program use one column cycle followed by two row cycles. Erase uses two row cycles. Any further address cycles are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch strobe |
| ale | input | 1 | Address latch strobe |
| we_n | input | 1 | Write enable; bytes are taken on its rising edge |
| re_n | input | 1 | Read enable; a byte is output on its falling edge |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Bus byte from the host |
| io_out | output | 8 | Bus byte to the host |
| io_oe | output | 1 | Output drive enable for io_out |
| rdy | output | 1 | Ready flag, low while busy |

## Verification
The bench programs every page with an arithmetic pattern. It then sweeps whole blocks through sequential reads. A design that wrapped inside one page, or carried on into the next block, returns bytes of the wrong page at the crossings and at the repeat of the block's final byte. Pointer starts are probed in the second half and in the spare area, including a spare column byte whose high nibble must be dropped. A design that adds the full byte reads a column 16 too far. Program is applied twice to one page to expose a design that overwrites instead of clearing bits. Program and erase are retried with write protect active, and the status byte is sampled while busy, after a refusal and after an abort. These probe the ready and fail bits and the claim that the array is untouched.

// File: rtl/nand_cmd_if.sv
module nand_cmd_if #(
  parameter int BLOCKS    = 2,
  parameter int BLK_PAGES = 2,
  parameter int RD_BUSY   = 8
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic       wp_n,
  input  logic [7:0] io_in,
  output logic [7:0] io_out,
  output logic       io_oe,
  output logic       rdy
);
  localparam int PAGE  = 528;
  localparam int PAGES = BLOCKS * BLK_PAGES;
  localparam int DEPTH = PAGES * PAGE;
  localparam int ROW_W = $clog2(PAGES);
  localparam int PG_W  = $clog2(BLK_PAGES);
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(BLK_PAGES * PAGE + 1);

  typedef enum logic [2:0] {M_READ, M_ID, M_STAT, M_PROG, M_ERASE} mode_t;
  typedef enum logic [1:0] {OP_RD, OP_PROG, OP_ERASE} op_t;

  logic [7:0]       mem   [DEPTH];
  logic [7:0]       buf_q [PAGE];
  logic             we_q, re_q, busy, fail;
  mode_t            mode;
  op_t              op;
  logic [1:0]       area, id_idx;
  logic [1:0]       acnt;
  logic [ROW_W-1:0] row;
  logic [9:0]       col, base, cstart;
  logic [CW-1:0]    cnt;
  logic [7:0]       data_q, status;
  logic [AW-1:0]    pbase, ebase;
  logic             cmd_stb, adr_stb, din_stb, re_fall, last_col, last_pg, stat_mode;

  wire sel     = !ce_n;
  wire we_rise = sel && !we_q && we_n;
  assign cmd_stb   = we_rise && cle && !ale;
  assign adr_stb   = we_rise && ale && !cle;
  assign din_stb   = we_rise && !cle && !ale;
  assign re_fall   = sel && re_q && !re_n && we_n && !cle && !ale;
  assign io_oe     = sel && !re_n && we_n && !cle && !ale;
  assign io_out    = data_q;
  assign rdy       = !busy;
  assign stat_mode = (mode == M_STAT);

  assign base     = (area == 2'd0) ? 10'd0 : (area == 2'd1) ? 10'd256 : 10'd512;
  assign cstart   = base + ((area == 2'd2) ? {6'd0, io_in[3:0]} : {2'd0, io_in});
  assign last_col = (col == 10'(PAGE - 1));
  assign last_pg  = &row[PG_W-1:0];
  assign status   = {wp_n, rdy, 5'b0, fail};
  assign pbase    = AW'(row) * AW'(PAGE);
  assign ebase    = AW'(row & ~ROW_W'(BLK_PAGES - 1)) * AW'(PAGE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < PAGE; i++) buf_q[i] <= 8'hFF;
      we_q <= 1'b1; re_q <= 1'b1; busy <= 1'b0; fail <= 1'b0;
      mode <= M_READ; op <= OP_RD; area <= 2'd0; id_idx <= 2'd0;
      acnt <= 2'd0; row <= '0; col <= '0; cnt <= '0; data_q <= 8'h00;
    end else begin
      we_q <= we_n;
      re_q <= re_n;

      if (busy) begin
        case (op)
          OP_RD: begin
            if (cnt == '0) busy <= 1'b0;
            else cnt <= cnt - 1'b1;
          end
          OP_PROG: begin
            mem[pbase + AW'(cnt)] <= mem[pbase + AW'(cnt)] & buf_q[cnt];
            if (cnt == CW'(PAGE - 1)) busy <= 1'b0;
            else cnt <= cnt + 1'b1;
          end
          default: begin
            mem[ebase + AW'(cnt)] <= 8'hFF;
            if (cnt == CW'(BLK_PAGES * PAGE - 1)) busy <= 1'b0;
            else cnt <= cnt + 1'b1;
          end
        endcase
      end

      if (cmd_stb) begin
        if (busy) begin
          if (io_in == 8'h70) mode <= M_STAT;
          else if (io_in == 8'hFF) begin
            busy <= 1'b0; mode <= M_READ; area <= 2'd0;
          end
        end else begin
          case (io_in)
            8'h00: begin area <= 2'd0; mode <= M_READ; acnt <= 2'd0; end
            8'h01: begin area <= 2'd1; mode <= M_READ; acnt <= 2'd0; end
            8'h50: begin area <= 2'd2; mode <= M_READ; acnt <= 2'd0; end
            8'h80: begin
              mode <= M_PROG; acnt <= 2'd0;
              for (int i = 0; i < PAGE; i++) buf_q[i] <= 8'hFF;
            end
            8'h10: if (mode == M_PROG) begin
              mode <= M_READ;
              if (!wp_n) fail <= 1'b1;
              else begin fail <= 1'b0; busy <= 1'b1; op <= OP_PROG; cnt <= '0; end
            end
            8'h60: begin mode <= M_ERASE; acnt <= 2'd0; end
            8'hD0: if (mode == M_ERASE && acnt >= 2'd2) begin
              mode <= M_READ;
              if (!wp_n) fail <= 1'b1;
              else begin fail <= 1'b0; busy <= 1'b1; op <= OP_ERASE; cnt <= '0; end
            end
            8'h90: begin mode <= M_ID; id_idx <= 2'd0; end
            8'h70: mode <= M_STAT;
            8'hFF: begin mode <= M_READ; area <= 2'd0; end
            default: ;
          endcase
        end
      end

      if (adr_stb && !busy) begin
        if (mode == M_READ || mode == M_PROG) begin
          if (acnt == 2'd0) col <= cstart;
          if (acnt == 2'd1) row <= io_in[ROW_W-1:0];
          if (acnt == 2'd2 && mode == M_READ) begin
            busy <= 1'b1; op <= OP_RD; cnt <= CW'(RD_BUSY - 1);
          end
          if (acnt != 2'd3) acnt <= acnt + 1'b1;
        end else if (mode == M_ERASE) begin
          if (acnt == 2'd0) row <= io_in[ROW_W-1:0];
          if (acnt != 2'd3) acnt <= acnt + 1'b1;
        end
      end

      if (din_stb && !busy && mode == M_PROG && acnt == 2'd3) begin
        buf_q[col] <= io_in;
        if (!last_col) col <= col + 1'b1;
      end

      if (re_fall) begin
        case (mode)
          M_STAT: data_q <= status;
          M_ID: begin
            data_q <= (id_idx == 2'd0) ? 8'h20 : (id_idx == 2'd1) ? 8'h75 : 8'h00;
            if (id_idx != 2'd3) id_idx <= id_idx + 1'b1;
          end
          M_READ: if (!busy) begin
            data_q <= mem[pbase + AW'(col)];
            if (!last_col) col <= col + 1'b1;
            else if (!last_pg) begin
              row <= row + 1'b1; col <= base;
              busy <= 1'b1; op <= OP_RD; cnt <= CW'(RD_BUSY - 1);
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/nand_cmd_if_chk.sv
module nand_cmd_if_chk #(
  parameter int PAGE = 528
)(
  input logic       clk,
  input logic       rst_n,
  input logic       wp_n,
  input logic       rdy,
  input logic       cmd_stb,
  input logic       re_fall,
  input logic       stat_mode,
  input logic [7:0] io_out,
  input logic [9:0] col
);
  assert_wp_refuse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && !wp_n && rdy) |=> rdy);

  assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !re_fall |=> $stable(io_out));

  assert_col_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    col <= 10'(PAGE - 1));

  assert_status_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (re_fall && stat_mode) |=> (io_out[7:6] == {$past(wp_n), $past(rdy)} && io_out[5:1] == 5'b0));
endmodule

bind nand_cmd_if nand_cmd_if_chk #(.PAGE(528)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .rdy(rdy), .cmd_stb(cmd_stb),
  .re_fall(re_fall), .stat_mode(stat_mode), .io_out(io_out), .col(col)
);

// File: tb/tb_nand_cmd_if.sv
module tb_nand_cmd_if;
  localparam int PAGE = 528;
  localparam int BLKP = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [7:0] io_in = 8'h00;
  logic [7:0] io_out;
  logic io_oe, rdy;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nand_cmd_if dut (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .wp_n(wp_n), .io_in(io_in), .io_out(io_out),
    .io_oe(io_oe), .rdy(rdy));

  function automatic logic [7:0] pat(int p, int c);
    return 8'((p * 7 + c * 3 + 1) & 255);
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic c, logic a, logic [7:0] d);
    @(negedge clk); cle = c; ale = a; io_in = d; we_n = 1'b0;
    repeat (2) @(negedge clk); we_n = 1'b1;
    repeat (2) @(negedge clk); cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(logic [7:0] d); wr(1'b1, 1'b0, d); endtask
  task automatic adr(logic [7:0] d); wr(1'b0, 1'b1, d); endtask
  task automatic din(logic [7:0] d); wr(1'b0, 1'b0, d); endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); re_n = 1'b0;
    @(negedge clk); v = io_out;
    total++;
    if (io_oe !== 1'b1) begin bad++; $display("FAIL R4 io_oe got=%b exp=1", io_oe); end
    re_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitr();
    int n = 0;
    while (!rdy && n < 5000) begin @(negedge clk); n++; end
    total++;
    if (!rdy) begin bad++; $display("FAIL R11 rdy got=0 exp=1"); end
  endtask

  task automatic open_page(logic [7:0] pc, logic [7:0] c, int p);
    cmd(pc); adr(c); adr(8'(p)); adr(8'h00); waitr();
  endtask

  task automatic sweep(int blk, bit erased);
    logic [7:0] v;
    open_page(8'h00, 8'h00, blk * BLKP);
    for (int p = blk * BLKP; p < (blk + 1) * BLKP; p++)
      for (int c = 0; c < PAGE; c++) begin
        waitr(); rd(v);
        chk(erased ? "R7 erased byte" : "R5 R6 sequential byte", v, erased ? 8'hFF : pat(p, c));
      end
    waitr(); rd(v);
    chk("R5 block end repeat", v, erased ? 8'hFF : pat((blk + 1) * BLKP - 1, PAGE - 1));
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdy after reset", {7'd0, rdy}, 8'd1);
    chk("R1 io_oe after reset", {7'd0, io_oe}, 8'd0);
    cmd(8'h70); rd(v); chk("R1 R9 reset status", v, 8'hC0);
    cmd(8'h00); adr(8'h00); adr(8'h01); adr(8'h00); waitr(); rd(v);
    chk("R1 array erased after reset", v, 8'hFF);

    cmd(8'h90); adr(8'h00); rd(v); chk("R8 maker id", v, 8'h20);
    rd(v); chk("R8 device id", v, 8'h75);

    cmd(8'h70);
    ce_n = 1'b1; cmd(8'h90); ce_n = 1'b0;
    rd(v); chk("R2 deselected command ignored", v, 8'hC0);

    for (int p = 0; p < 2 * BLKP; p++) begin
      cmd(8'h00); cmd(8'h80); adr(8'h00); adr(8'(p)); adr(8'h00);
      for (int c = 0; c < PAGE; c++) din(pat(p, c));
      cmd(8'h10);
      chk("R11 busy during program", {7'd0, rdy}, 8'd0);
      waitr();
    end
    sweep(0, 1'b0);
    sweep(1, 1'b0);

    cmd(8'h01); adr(8'h05); adr(8'h02); adr(8'h00);
    chk("R11 busy after read address", {7'd0, rdy}, 8'd0);
    waitr(); rd(v); chk("R3 second half start", v, pat(2, 261));
    rd(v); chk("R4 column advance", v, pat(2, 262));
    @(negedge clk); chk("R4 io_oe idle", {7'd0, io_oe}, 8'd0);
    chk("R4 io_out held", io_out, pat(2, 262));
    open_page(8'h50, 8'h13, 2); rd(v); chk("R3 spare low nibble", v, pat(2, 515));
    open_page(8'h50, 8'h0E, 0); rd(v); chk("R3 spare start", v, pat(0, 526));
    waitr(); rd(v); chk("R5 last column", v, pat(0, 527));
    waitr(); rd(v); chk("R5 next page at area base", v, pat(1, 512));
    cmd(8'h00); adr(8'h07); adr(8'h03); adr(8'h00); adr(8'h55); adr(8'h99);
    waitr(); rd(v); chk("R12 extra address ignored", v, pat(3, 7));

    cmd(8'h60); adr(8'h02); adr(8'h00); adr(8'h01); cmd(8'hD0);
    cmd(8'h70); rd(v); chk("R11 R9 status while busy", v, 8'h80);
    cmd(8'h00); chk("R11 read command ignored while busy", {7'd0, rdy}, 8'd0);
    waitr();
    cmd(8'h70); rd(v); chk("R9 status ready pass", v, 8'hC0);
    sweep(1, 1'b1);
    open_page(8'h00, 8'h09, 1); rd(v); chk("R7 other block intact", v, pat(1, 9));

    cmd(8'h80); adr(8'h00); adr(8'h02); adr(8'h00);
    for (int i = 0; i < 4; i++) din(8'hA5);
    cmd(8'h10); waitr();
    open_page(8'h00, 8'h00, 2);
    for (int c = 0; c < 6; c++) begin
      rd(v); chk("R6 partial program", v, (c < 4) ? 8'hA5 : 8'hFF);
    end
    cmd(8'h80); adr(8'h00); adr(8'h02); adr(8'h00); din(8'h0F); cmd(8'h10); waitr();
    open_page(8'h00, 8'h00, 2); rd(v); chk("R6 bits only cleared", v, 8'h05);

    wp_n = 1'b0;
    cmd(8'h80); adr(8'h00); adr(8'h02); adr(8'h00); din(8'h00); cmd(8'h10);
    chk("R10 program refused rdy", {7'd0, rdy}, 8'd1);
    cmd(8'h70); rd(v); chk("R10 status fail protected", v, 8'h41);
    rd(v); chk("R9 status persists", v, 8'h41);
    cmd(8'h60); adr(8'h02); adr(8'h00); cmd(8'hD0);
    chk("R10 erase refused rdy", {7'd0, rdy}, 8'd1);
    open_page(8'h00, 8'h00, 2); rd(v); chk("R10 array unchanged", v, 8'h05);
    wp_n = 1'b1;

    cmd(8'h60); adr(8'h02); adr(8'h00); cmd(8'hD0);
    cmd(8'h70); rd(v); chk("R10 accepted confirm clears fail", v, 8'h80);
    cmd(8'hFF);
    chk("R11 abort clears busy", {7'd0, rdy}, 8'd1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule